// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, frame by frame, whether a received frame should be kept, based only on its 48-bit destination address. Upstream logic presents the address, the CRC-32 already computed over it, and a one-cycle strobe. One clock later the filter returns an accept flag and a code that says which rule let the frame in.

Four rules are applied. The all-ones broadcast address always passes. A unicast address passes when it equals one of two programmable station addresses. A group (multicast) address passes when its entry in a 512-bit hash table is set. The index of that entry is the top nine bits of the CRC. A promiscuous input accepts everything. Each station address is loaded as a 32-bit low word and a 16-bit high word through a small register-write port. The hash table is changed one entry at a time through a control word and can be wiped in a single cycle.

Top module: `rx_addr_filter`

## Requirements
- R1: A synchronous reset drives `acc_valid` low and sets both station addresses to zero. It also clears every hash entry.
- R2: A station write with `sta_wr_en` high loads one register, chosen by `sta_wr_sel`: 0 is station 0 low, 1 is station 0 high, 2 is station 1 low, 3 is station 1 high. A low register holds address bits 31:0 from `sta_wr_data[31:0]`. A high register holds address bits 47:32 from `sta_wr_data[15:0]`.
- R3: A unicast address, with bit 40 clear, is accepted when it equals a station address. The reason is 1 for station 0 and 2 for station 1. Station 0 wins when both match.
- R4: With `promisc` low, a unicast address that matches no station address is rejected with reason 0.
- R5: The address 48'hFFFF_FFFF_FFFF is always accepted with reason 3.
- R6: A group address, with bit 40 set and not broadcast, is looked up at hash index `da_crc[31:23]`. It is accepted with reason 4 when that entry is 1. With `promisc` low it is rejected with reason 0 when that entry is 0.
- R7: A hash write with `hash_wr_en` high takes the entry index from `hash_wr_word[8:0]`. It sets that entry when `hash_wr_word[9]` is 1 and clears it when that bit is 0. No other entry changes.
- R8: `hash_clr` empties all 512 entries in one cycle. It overrides a hash write in the same cycle.
- R9: With `promisc` high, every frame is accepted. The reason is 5 when none of the rules of R3, R5 and R6 applies; otherwise it is that rule's code.
- R10: The decision is registered. `acc_valid` is high exactly one cycle after `da_valid`, and `acc` and `acc_reason` are 0 in any other cycle. A station or hash write in the same cycle as the strobe is not seen by that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sta_wr_en | input | 1 | Station register write strobe |
| sta_wr_sel | input | 2 | Station register select |
| sta_wr_data | input | 32 | Station register write data |
| hash_wr_en | input | 1 | Hash entry write strobe |
| hash_wr_word | input | 10 | Hash control word: set flag in bit 9, index in bits 8:0 |
| hash_clr | input | 1 | Clear whole hash table |
| promisc | input | 1 | Accept all frames |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, bit 40 is the group bit |
| da_crc | input | 32 | CRC-32 over the destination address |
| acc_valid | output | 1 | Decision valid |
| acc | output | 1 | Frame accepted |
| acc_reason | output | 3 | 0 reject, 1 station 0, 2 station 1, 3 broadcast, 4 hash, 5 promiscuous |

## Verification
Every decision is due on the clock edge that follows the edge that captured the strobe. A station or hash write takes effect on the edge that captures it, so the first strobe that can see it comes one cycle later. The bench drives all inputs on the falling edge. It reads the decision at the next falling edge, which lies half a period after the edge that registered it. It also checks the cycle after that, to confirm the valid flag drops. Writes that share a cycle with a strobe, and a clear that shares a cycle with a write, are driven on the same falling edge. Their effect is then probed by later strobes.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  localparam int STA_NUM = 2;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_STA0    = 3'd1,
    RSN_STA1    = 3'd2,
    RSN_BCAST   = 3'd3,
    RSN_HASH    = 3'd4,
    RSN_PROMISC = 3'd5
  } reason_e;
endpackage

// File: rtl/station_regs.sv
module station_regs #(
  parameter int NUM_STA = rx_addr_filter_pkg::STA_NUM,
  parameter int LO_W    = 32,
  parameter int HI_W    = 16,
  localparam int AW     = LO_W + HI_W,
  localparam int SEL_W  = $clog2(2 * NUM_STA)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [LO_W-1:0]  wr_data,
  output logic [AW-1:0]    sta_addr [NUM_STA]
);

  for (genvar g = 0; g < NUM_STA; g++) begin : g_sta
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_en) begin
        if (wr_sel == SEL_W'(2 * g))     lo_q <= wr_data;
        if (wr_sel == SEL_W'(2 * g + 1)) hi_q <= wr_data[HI_W-1:0];
      end
    end

    assign sta_addr[g] = {hi_q, lo_q};

    // R2
    sta_lo_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == SEL_W'(2 * g)) |=> (sta_addr[g][LO_W-1:0] == $past(wr_data)));

    // R2
    sta_hi_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == SEL_W'(2 * g + 1)) |=> (sta_addr[g][AW-1:LO_W] == $past(wr_data[HI_W-1:0])));
  end

endmodule

// File: rtl/hash_table.sv
module hash_table #(
  parameter int IDX_W  = 9,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic             wr_set,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);

  logic [DEPTH-1:0] tbl;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tbl <= '0;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_set;
    end
  end

  assign rd_bit = tbl[rd_idx];

  // R8
  tbl_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (tbl == '0));

  // R7
  tbl_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> (tbl[$past(wr_idx)] == $past(wr_set)));

endmodule

// File: rtl/match_decide.sv
module match_decide
  import rx_addr_filter_pkg::*;
#(
  parameter int AW        = 48,
  parameter int GROUP_BIT = AW - 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          da_valid,
  input  logic [AW-1:0] da,
  input  logic [AW-1:0] sta_addr [STA_NUM],
  input  logic          hash_hit,
  input  logic          promisc,
  output logic          acc_valid,
  output logic          acc,
  output reason_e       reason
);

  logic [STA_NUM-1:0] sta_hit;
  logic               is_bcast;
  logic               is_group;
  logic               acc_d;
  reason_e            rsn_d;

  for (genvar g = 0; g < STA_NUM; g++) begin : g_cmp
    assign sta_hit[g] = (da == sta_addr[g]);
  end

  assign is_bcast = &da;
  assign is_group = da[GROUP_BIT];

  always_comb begin
    acc_d = 1'b1;
    if (is_bcast)                  rsn_d = RSN_BCAST;
    else if (!is_group && sta_hit[0]) rsn_d = RSN_STA0;
    else if (!is_group && sta_hit[1]) rsn_d = RSN_STA1;
    else if (is_group && hash_hit) rsn_d = RSN_HASH;
    else if (promisc)              rsn_d = RSN_PROMISC;
    else begin
      rsn_d = RSN_NONE;
      acc_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      acc       <= 1'b0;
      reason    <= RSN_NONE;
    end else begin
      acc_valid <= da_valid;
      acc       <= da_valid & acc_d;
      reason    <= da_valid ? rsn_d : RSN_NONE;
    end
  end

  // R10
  dec_valid_chk: assert property (@(posedge clk) disable iff (rst)
    da_valid |=> acc_valid);

  // R10
  dec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !da_valid |=> (!acc_valid && !acc && reason == RSN_NONE));

  // R9
  promisc_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (da_valid && promisc) |=> acc);

  // R5
  bcast_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (da_valid && (&da)) |=> (acc && reason == RSN_BCAST));

  // R6
  mc_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (da_valid && !promisc && da[GROUP_BIT] && !(&da) && !hash_hit) |=> !acc);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int REG_W      = 32,
  parameter int CRC_W      = 32,
  parameter int HASH_IDX_W = 9,
  localparam int HI_W      = ADDR_W - REG_W,
  localparam int SEL_W     = $clog2(2 * STA_NUM),
  localparam int CRC_SHIFT = CRC_W - HASH_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sta_wr_en,
  input  logic [SEL_W-1:0]      sta_wr_sel,
  input  logic [REG_W-1:0]      sta_wr_data,
  input  logic                  hash_wr_en,
  input  logic [HASH_IDX_W:0]   hash_wr_word,
  input  logic                  hash_clr,
  input  logic                  promisc,
  input  logic                  da_valid,
  input  logic [ADDR_W-1:0]     da,
  input  logic [CRC_W-1:0]      da_crc,
  output logic                  acc_valid,
  output logic                  acc,
  output logic [2:0]            acc_reason
);

  logic [ADDR_W-1:0]     sta_addr [STA_NUM];
  logic [HASH_IDX_W-1:0] lookup_idx;
  logic                  hash_hit;
  reason_e               reason;

  assign lookup_idx = HASH_IDX_W'(da_crc >> CRC_SHIFT);

  station_regs #(
    .NUM_STA (STA_NUM),
    .LO_W    (REG_W),
    .HI_W    (HI_W)
  ) u_sta (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (sta_wr_en),
    .wr_sel   (sta_wr_sel),
    .wr_data  (sta_wr_data),
    .sta_addr (sta_addr)
  );

  hash_table #(
    .IDX_W (HASH_IDX_W)
  ) u_hash (
    .clk    (clk),
    .rst    (rst),
    .clr    (hash_clr),
    .wr_en  (hash_wr_en),
    .wr_set (hash_wr_word[HASH_IDX_W]),
    .wr_idx (hash_wr_word[HASH_IDX_W-1:0]),
    .rd_idx (lookup_idx),
    .rd_bit (hash_hit)
  );

  match_decide #(
    .AW (ADDR_W)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .da_valid  (da_valid),
    .da        (da),
    .sta_addr  (sta_addr),
    .hash_hit  (hash_hit),
    .promisc   (promisc),
    .acc_valid (acc_valid),
    .acc       (acc),
    .reason    (reason)
  );

  assign acc_reason = reason;

endmodule

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb;

  localparam real CLK_HALF = 2.5;
  localparam int  NVEC     = 14;
  localparam logic [47:0] STA0 = 48'h02_11_22_33_44_55;
  localparam logic [47:0] STA1 = 48'h0A_BB_CC_DD_EE_F0;
  localparam logic [47:0] MC   = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] BC   = 48'hFF_FF_FF_FF_FF_FF;

  // {promisc, da, crc, exp_acc, exp_reason}
  localparam logic [84:0] VEC [NVEC] = '{
    {1'b0, STA0, 32'h0000_0000, 1'b1, 3'd1},            // R3
    {1'b0, STA1, 32'h0000_0000, 1'b1, 3'd2},            // R3
    {1'b0, 48'h02_11_22_33_44_54, 32'h0, 1'b0, 3'd0},   // R4
    {1'b0, BC,   32'h0000_0000, 1'b1, 3'd3},            // R5
    {1'b0, MC,   32'hD280_1234, 1'b1, 3'd4},            // R6 idx 1A5
    {1'b0, MC,   32'hD200_0000, 1'b0, 3'd0},            // R6 idx 1A4
    {1'b0, MC,   32'hFF80_0000, 1'b1, 3'd4},            // R6 idx 1FF
    {1'b0, MC,   32'h0000_1234, 1'b1, 3'd4},            // R6 idx 000
    {1'b0, MC,   32'h0080_0000, 1'b0, 3'd0},            // R6 idx 001
    {1'b0, 48'hFE_FF_FF_FF_FF_FF, 32'h0, 1'b0, 3'd0},   // R4
    {1'b1, 48'h02_11_22_33_44_54, 32'h0, 1'b1, 3'd5},   // R9
    {1'b1, STA0, 32'h0000_0000, 1'b1, 3'd1},            // R9
    {1'b1, MC,   32'hD200_0000, 1'b1, 3'd5},            // R9
    {1'b1, BC,   32'h0000_0000, 1'b1, 3'd3}             // R9
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sta_wr_en = 1'b0;
  logic [1:0]  sta_wr_sel = '0;
  logic [31:0] sta_wr_data = '0;
  logic        hash_wr_en = 1'b0;
  logic [9:0]  hash_wr_word = '0;
  logic        hash_clr = 1'b0;
  logic        promisc = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da = '0;
  logic [31:0] da_crc = '0;
  logic        acc_valid;
  logic        acc;
  logic [2:0]  acc_reason;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_HALF) clk = ~clk;

  rx_addr_filter u_dut (
    .clk          (clk),
    .rst          (rst),
    .sta_wr_en    (sta_wr_en),
    .sta_wr_sel   (sta_wr_sel),
    .sta_wr_data  (sta_wr_data),
    .hash_wr_en   (hash_wr_en),
    .hash_wr_word (hash_wr_word),
    .hash_clr     (hash_clr),
    .promisc      (promisc),
    .da_valid     (da_valid),
    .da           (da),
    .da_crc       (da_crc),
    .acc_valid    (acc_valid),
    .acc          (acc),
    .acc_reason   (acc_reason)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_sta(input logic [1:0] sel, input logic [31:0] data);
    sta_wr_en = 1'b1; sta_wr_sel = sel; sta_wr_data = data;
    cycle();
    sta_wr_en = 1'b0;
  endtask

  task automatic wr_hash(input logic [9:0] word);
    hash_wr_en = 1'b1; hash_wr_word = word;
    cycle();
    hash_wr_en = 1'b0;
  endtask

  // strobe one address, then read the decision half a period after it registers
  task automatic probe(input string tag, input logic p, input logic [47:0] a,
                       input logic [31:0] c, input logic eacc, input logic [2:0] ersn);
    promisc = p; da = a; da_crc = c; da_valid = 1'b1;
    cycle();
    da_valid = 1'b0; hash_wr_en = 1'b0; hash_clr = 1'b0;
    check(tag, {2'b00, acc_valid, acc, 1'b0} | {2'b00, 1'b0, 1'b0, 1'b0}, {2'b00, 1'b1, eacc, 1'b0});
    check(tag, {2'b00, acc_reason}, {2'b00, ersn});
    promisc = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 valid after reset", {4'b0, acc_valid}, 5'd0);
    probe("R1 station regs zero", 1'b0, 48'h0, 32'h0, 1'b1, 3'd1);
    probe("R1 hash empty", 1'b0, MC, 32'hD280_0000, 1'b0, 3'd0);

    // R2: program stations
    wr_sta(2'd0, 32'h2233_4455);
    wr_sta(2'd1, 32'hFFFF_0211);
    wr_sta(2'd2, 32'hCCDD_EEF0);
    wr_sta(2'd3, 32'h0000_0ABB);
    // R7: set entries
    wr_hash({1'b1, 9'h1A5});
    wr_hash({1'b1, 9'h1FF});
    wr_hash({1'b1, 9'h000});

    for (int i = 0; i < NVEC; i++) begin
      probe($sformatf("vector %0d R2/R3/R4/R5/R6/R9", i), VEC[i][84], VEC[i][83:36],
            VEC[i][35:4], VEC[i][3], VEC[i][2:0]);
    end

    // R10: valid drops the cycle after
    probe("R10 strobe", 1'b0, STA0, 32'h0, 1'b1, 3'd1);
    cycle();
    check("R10 idle", {2'b0, acc_valid, acc, |acc_reason}, 5'd0);

    // R10: write in the strobe cycle is not seen by that strobe
    hash_wr_en = 1'b1; hash_wr_word = {1'b1, 9'h1A4};
    probe("R10 same-cycle write", 1'b0, MC, 32'hD200_0000, 1'b0, 3'd0);
    probe("R7 set visible later", 1'b0, MC, 32'hD200_0000, 1'b1, 3'd4);

    // R7: clear one entry, neighbours intact
    wr_hash({1'b0, 9'h1A5});
    probe("R7 cleared entry", 1'b0, MC, 32'hD280_0000, 1'b0, 3'd0);
    probe("R7 other entry kept", 1'b0, MC, 32'hFF80_0000, 1'b1, 3'd4);

    // R3: both stations equal, station 0 wins
    wr_sta(2'd2, 32'h2233_4455);
    wr_sta(2'd3, 32'h0000_0211);
    probe("R3 priority", 1'b0, STA0, 32'h0, 1'b1, 3'd1);
    probe("R4 old station1 gone", 1'b0, STA1, 32'h0, 1'b0, 3'd0);

    // R8: clear overrides simultaneous write
    hash_clr = 1'b1; hash_wr_en = 1'b1; hash_wr_word = {1'b1, 9'h100};
    cycle();
    hash_clr = 1'b0; hash_wr_en = 1'b0;
    probe("R8 write lost", 1'b0, MC, 32'h8000_0000, 1'b0, 3'd0);
    probe("R8 entry 1FF cleared", 1'b0, MC, 32'hFF80_0000, 1'b0, 3'd0);
    probe("R8 entry 000 cleared", 1'b0, MC, 32'h0000_0000, 1'b0, 3'd0);

    // R1: reset in mid run
    wr_hash({1'b1, 9'h1FF});
    rst = 1'b1;
    cycle();
    rst = 1'b0;
    check("R1 valid after rerun reset", {4'b0, acc_valid}, 5'd0);
    probe("R1 hash wiped", 1'b0, MC, 32'hFF80_0000, 1'b0, 3'd0);
    probe("R1 station wiped", 1'b0, STA0, 32'h0, 1'b0, 3'd0);
    probe("R1 station zero match", 1'b0, 48'h0, 32'h0, 1'b1, 3'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_HALF * 2.0 * 150000.0);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule